// File: doc/BRIEF.md
# Programmed Transfer Controller

This unit sequences a multi-beat transfer between a local FIFO pair and an external parallel bus. Software loads a beat count and a target (device select plus address), then writes the control word. That word carries the direction, a lead-in pad count and the start request. The unit then asks a separate timing engine for one bus access per beat. It holds each request until the engine acknowledges it, and it reports progress through active, done and error flags and a single interrupt line.

Pad beats work differently in each direction. On a read, the first acknowledged beats carry junk, so they are marked for discard instead of being pushed into the receive FIFO. On a write, the unit first pops and discards that many entries from the transmit FIFO, and only then issues bus accesses. A read is not reported complete until the receive FIFO has been drained. Changing the count or target while a transfer runs is refused and leaves a sticky error flag.

Register writes use a select code: 0 is control, 1 is count, 2 is target, and 3 is ignored. The control fields are: bit 0 enable, bit 1 start, bit 2 direction (1 means write to the device), bits 4:3 pad count, bit 5 receive interrupt enable, bit 6 transmit interrupt enable, bit 7 done interrupt enable, and bit 8 error clear. The count is held in bits 15:0. The target holds the address in bits 5:0 and the device in bits 9:8.

Top module: `xfer_ctrl`

## Requirements
- R1: A control write with bit 1 and bit 0 both set, made while idle, starts a transfer, and `xfer_active` is high from the next cycle until the transfer ends. A start made while active is ignored, and so is a start whose bit 0 is 0.
- R2: A transfer issues exactly the programmed count of accesses. `acc_req` stays high until a cycle with `acc_ack`, then is low for at least one cycle. `acc_dir`, `acc_addr` and `acc_dev` show the stored direction and target.
- R3: `xfer_done` rises after the last access of a write. For a read, it rises only once `rx_empty` is high after the last access. It then stays high until the next accepted start clears it.
- R4: On a read with pad count P, the first P acknowledged beats raise `rx_drop` instead of `rx_push`. Every later beat raises `rx_push`.
- R5: On a write with pad count P, the unit raises `tx_skip` P times, in cycles where `tx_empty` is low, before its first access.
- R6: While the enable bit is 0, no new access is requested and no skip is made. An access already requested still completes, and the transfer resumes when enable returns.
- R7: A count or target write made while active is discarded and sets `setup_err`. A control write with bit 8 set clears it. Direction and pad bits in a control write made while active are ignored.
- R8: `irq` is high when any of these holds: receive enable with `rx_need`, transmit enable with `tx_need`, or done enable with `xfer_done`.
- R9: A transfer with count 0 and no pad completes without any access. A write sets done two cycles after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 count, 2 target |
| wr_data | input | 32 | Register write data |
| acc_req | output | 1 | Access request to the timing engine |
| acc_dir | output | 1 | Access direction, 1 = write to device |
| acc_dev | output | 2 | Device select for the access |
| acc_addr | output | 6 | External address for the access |
| acc_ack | input | 1 | Timing engine has completed the requested access |
| rx_push | output | 1 | Push the current read beat into the receive FIFO |
| rx_drop | output | 1 | Discard the current read beat (pad) |
| rx_empty | input | 1 | Receive FIFO is empty |
| rx_need | input | 1 | Receive FIFO needs servicing |
| tx_skip | output | 1 | Pop and discard one transmit FIFO entry (pad) |
| tx_empty | input | 1 | Transmit FIFO is empty |
| tx_need | input | 1 | Transmit FIFO needs refilling |
| xfer_active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | Transfer finished (sticky) |
| setup_err | output | 1 | Sticky setup-write error |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that the timing engine raises `acc_ack` only while a request is pending. They also assume that `wr_en` is a single-cycle strobe carrying one register at a time, and that `rx_empty` and `tx_empty` reflect a real FIFO, not glitches. The stimulus keeps to these rules. A behavioural engine acknowledges only requests that the reference model holds, after a chosen latency of 0 to 3 cycles. Register writes last one cycle each. FIFO flags change only at negative edges and are held for many cycles at a time.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_COUNT  = 2'd1;
  localparam logic [1:0] SEL_TARGET = 2'd2;
  localparam int B_EN       = 0;
  localparam int B_START    = 1;
  localparam int B_DIR      = 2;
  localparam int PAD_LSB    = 3;
  localparam int TGT_DEV_LSB = 8;
  localparam int N_IRQ      = 3;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_DRAIN = 2'd2} xfer_state_t;
endpackage

// File: rtl/xfer_rst_sync.sv
module xfer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/xfer_regs.sv
module xfer_regs
  import xfer_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 6,
  parameter int DEV_W  = 2,
  parameter int PAD_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              start_go,
  output logic [PAD_W-1:0]  pad_ld,
  output logic              en_q,
  output logic              dir_q,
  output logic [N_IRQ-1:0]  ie_q,
  output logic [LEN_W-1:0]  cnt_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DEV_W-1:0]  dev_q,
  output logic              err_q
);
  localparam int IE_LSB  = PAD_LSB + PAD_W;
  localparam int CLR_BIT = IE_LSB + N_IRQ;

  logic              ctrl_wr, cnt_wr, tgt_wr, setup_hit, reg_upd;
  logic              en_d, dir_d, err_d;
  logic [N_IRQ-1:0]  ie_d;
  logic [LEN_W-1:0]  cnt_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DEV_W-1:0]  dev_d;

  assign ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
  assign cnt_wr    = wr_en && (wr_sel == SEL_COUNT);
  assign tgt_wr    = wr_en && (wr_sel == SEL_TARGET);
  assign setup_hit = (cnt_wr || tgt_wr) && busy;
  assign start_go  = ctrl_wr && wr_data[B_START] && wr_data[B_EN] && !busy;
  assign pad_ld    = wr_data[PAD_LSB +: PAD_W];
  assign reg_upd   = ctrl_wr || cnt_wr || tgt_wr;

  always_comb begin
    en_d   = en_q;
    dir_d  = dir_q;
    ie_d   = ie_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    dev_d  = dev_q;
    err_d  = err_q;
    if (ctrl_wr) begin
      en_d = wr_data[B_EN];
      ie_d = wr_data[IE_LSB +: N_IRQ];
      if (!busy) dir_d = wr_data[B_DIR];
      if (wr_data[CLR_BIT]) err_d = 1'b0;
    end
    if (setup_hit) begin
      err_d = 1'b1;
    end else begin
      if (cnt_wr) cnt_d = wr_data[LEN_W-1:0];
      if (tgt_wr) begin
        addr_d = wr_data[ADDR_W-1:0];
        dev_d  = wr_data[TGT_DEV_LSB +: DEV_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      ie_q   <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
      dev_q  <= '0;
      err_q  <= 1'b0;
    end else if (reg_upd) begin
      en_q   <= en_d;
      dir_q  <= dir_d;
      ie_q   <= ie_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      dev_q  <= dev_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int PAD_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_go,
  input  logic [LEN_W-1:0] cnt,
  input  logic [PAD_W-1:0] pad_ld,
  input  logic             dir,
  input  logic             en,
  input  logic             acc_ack,
  input  logic             rx_empty,
  input  logic             tx_empty,
  output logic             acc_req,
  output logic             busy,
  output logic             done,
  output logic             rx_push,
  output logic             rx_drop,
  output logic             tx_skip
);
  xfer_state_t      st_q, st_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [PAD_W-1:0] padl_q, padl_d;
  logic             req_q, req_d, done_q, done_d;
  logic             run, rd, ack, pad_pend, skip, issue, finish, seq_upd;

  assign run      = (st_q == ST_RUN);
  assign rd       = !dir;
  assign ack      = run && req_q && acc_ack;
  assign pad_pend = (padl_q != '0);
  assign skip     = run && dir && pad_pend && en && !tx_empty;
  assign issue    = run && !req_q && (left_q != '0) && en && (rd || !pad_pend);
  assign finish   = run && !req_q && (left_q == '0) && (rd || !pad_pend);
  assign seq_upd  = start_go || (st_q != ST_IDLE);

  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    padl_d = padl_q;
    req_d  = req_q;
    done_d = done_q;
    if (start_go) begin
      st_d   = ST_RUN;
      left_d = cnt;
      padl_d = pad_ld;
      req_d  = 1'b0;
      done_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (ack) begin
            left_d = left_q - 1'b1;
            req_d  = 1'b0;
            if (rd && pad_pend) padl_d = padl_q - 1'b1;
          end
          if (skip)  padl_d = padl_q - 1'b1;
          if (issue) req_d = 1'b1;
          if (finish) begin
            st_d   = dir ? ST_IDLE : ST_DRAIN;
            done_d = dir;
          end
        end
        ST_DRAIN: begin
          if (rx_empty) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      padl_q <= '0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (seq_upd) begin
      st_q   <= st_d;
      left_q <= left_d;
      padl_q <= padl_d;
      req_q  <= req_d;
      done_q <= done_d;
    end
  end

  assign acc_req = req_q;
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign rx_push = ack && rd && !pad_pend;
  assign rx_drop = ack && rd && pad_pend;
  assign tx_skip = skip;
endmodule

// File: rtl/xfer_irq.sv
module xfer_irq #(
  parameter int N = 3
) (
  input  logic [N-1:0] ie,
  input  logic [N-1:0] cond,
  output logic         irq
);
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_src
    assign hit[g] = ie[g] & cond[g];
  end

  assign irq = |hit;
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 6,
  parameter int DEV_W  = 2,
  parameter int PAD_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              acc_req,
  output logic              acc_dir,
  output logic [DEV_W-1:0]  acc_dev,
  output logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_ack,
  output logic              rx_push,
  output logic              rx_drop,
  input  logic              rx_empty,
  input  logic              rx_need,
  output logic              tx_skip,
  input  logic              tx_empty,
  input  logic              tx_need,
  output logic              xfer_active,
  output logic              xfer_done,
  output logic              setup_err,
  output logic              irq
);
  logic             rst_sync_n;
  logic             start_go, en_q, dir_q;
  logic [PAD_W-1:0] pad_ld;
  logic [N_IRQ-1:0] ie_q;
  logic [LEN_W-1:0] cnt_q;

  xfer_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  xfer_regs #(
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .DEV_W(DEV_W), .PAD_W(PAD_W), .DATA_W(DATA_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(xfer_active), .start_go(start_go), .pad_ld(pad_ld), .en_q(en_q),
    .dir_q(dir_q), .ie_q(ie_q), .cnt_q(cnt_q), .addr_q(acc_addr), .dev_q(acc_dev),
    .err_q(setup_err)
  );

  xfer_seq #(.LEN_W(LEN_W), .PAD_W(PAD_W)) i_seq (
    .clk(clk), .rst_n(rst_sync_n), .start_go(start_go), .cnt(cnt_q), .pad_ld(pad_ld),
    .dir(dir_q), .en(en_q), .acc_ack(acc_ack), .rx_empty(rx_empty), .tx_empty(tx_empty),
    .acc_req(acc_req), .busy(xfer_active), .done(xfer_done), .rx_push(rx_push),
    .rx_drop(rx_drop), .tx_skip(tx_skip)
  );

  xfer_irq #(.N(N_IRQ)) i_irq (
    .ie(ie_q), .cond({xfer_done, tx_need, rx_need}), .irq(irq)
  );

  assign acc_dir = dir_q;
endmodule

// File: rtl/xfer_ctrl_chk.sv
module xfer_ctrl_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [8:0] wr_lo,
  input logic       acc_req,
  input logic       acc_ack,
  input logic       acc_dir,
  input logic       rx_push,
  input logic       rx_drop,
  input logic       rx_empty,
  input logic       tx_skip,
  input logic       xfer_active,
  input logic       xfer_done,
  input logic       setup_err,
  input logic       en_q
);
  // R1
  active_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(xfer_active) |-> $past(wr_en && wr_sel == 2'd0 && wr_lo[1] && wr_lo[0]));
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_req && !acc_ack) |=> acc_req);
  // R2
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_req && acc_ack) |=> !acc_req);
  // R3
  done_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(xfer_done) |-> $past(acc_dir || rx_empty));
  // R3
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_sel == 2'd0 && wr_lo[1] && wr_lo[0] && !xfer_active) |=> !xfer_done);
  // R4
  push_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rx_push && rx_drop));
  // R5
  skip_no_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_skip |-> !acc_req);
  // R6
  req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(acc_req) |-> $past(en_q));
  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xfer_active && wr_en && (wr_sel == 2'd1 || wr_sel == 2'd2)) |=> setup_err);
  // R7
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_sel == 2'd0 && wr_lo[8]) |=> !setup_err);
endmodule

bind xfer_ctrl xfer_ctrl_chk i_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_lo(wr_data[8:0]), .acc_req(acc_req), .acc_ack(acc_ack), .acc_dir(acc_dir),
  .rx_push(rx_push), .rx_drop(rx_drop), .rx_empty(rx_empty), .tx_skip(tx_skip),
  .xfer_active(xfer_active), .xfer_done(xfer_done), .setup_err(setup_err), .en_q(en_q)
);

// File: tb/test_xfer_ctrl.sv
module test_xfer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        acc_req, acc_dir, acc_ack;
  logic [1:0]  acc_dev;
  logic [5:0]  acc_addr;
  logic        rx_push, rx_drop, rx_empty, rx_need;
  logic        tx_skip, tx_empty, tx_need;
  logic        xfer_active, xfer_done, setup_err, irq;

  int vectors = 0;
  int fails   = 0;

  // reference model state
  int m_state, m_left, m_padl, m_cnt, m_addr, m_dev;
  bit m_req, m_done, m_en, m_dir, m_err, m_ie_rx, m_ie_tx, m_ie_d;
  bit [1:0] m_rpipe;
  int lat, eng_wait;

  always #4 clk = ~clk;

  xfer_ctrl i_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .acc_req(acc_req), .acc_dir(acc_dir), .acc_dev(acc_dev), .acc_addr(acc_addr),
    .acc_ack(acc_ack), .rx_push(rx_push), .rx_drop(rx_drop), .rx_empty(rx_empty),
    .rx_need(rx_need), .tx_skip(tx_skip), .tx_empty(tx_empty), .tx_need(tx_need),
    .xfer_active(xfer_active), .xfer_done(xfer_done), .setup_err(setup_err), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_state = 0; m_left = 0; m_padl = 0; m_cnt = 0; m_addr = 0; m_dev = 0;
    m_req = 0; m_done = 0; m_en = 0; m_dir = 0; m_err = 0;
    m_ie_rx = 0; m_ie_tx = 0; m_ie_d = 0;
  endtask

  task automatic compare();
    bit ack = (m_state == 1) && m_req && acc_ack;
    bit e_irq = (m_ie_rx && rx_need) || (m_ie_tx && tx_need) || (m_ie_d && m_done);
    chk("R1 xfer_active", xfer_active, m_state != 0);
    chk("R2 acc_req", acc_req, m_req);
    chk("R2 acc_dir", acc_dir, m_dir);
    chk("R2 acc_addr", acc_addr, m_addr);
    chk("R2 acc_dev", acc_dev, m_dev);
    chk("R3 xfer_done", xfer_done, m_done);
    chk("R4 rx_push", rx_push, ack && !m_dir && m_padl == 0);
    chk("R4 rx_drop", rx_drop, ack && !m_dir && m_padl > 0);
    chk("R5 tx_skip", tx_skip, (m_state == 1) && m_dir && m_padl > 0 && m_en && !tx_empty);
    chk("R7 setup_err", setup_err, m_err);
    chk("R8 irq", irq, e_irq);
  endtask

  task automatic model_edge();
    bit ctrl = wr_en && wr_sel == 2'd0;
    bit busy = m_state != 0;
    bit go   = ctrl && wr_data[1] && wr_data[0] && !busy;
    bit ack  = (m_state == 1) && m_req && acc_ack;
    bit live = m_rpipe[1];
    if (acc_ack) eng_wait = 0;
    else if (m_req) eng_wait++;
    if (!rst_n) begin
      m_rpipe = 2'b00; model_reset(); eng_wait = 0;
      return;
    end
    m_rpipe = {m_rpipe[0], 1'b1};
    if (!live) return;
    if (go) begin
      m_state = 1; m_left = m_cnt; m_padl = int'(wr_data[4:3]); m_req = 0; m_done = 0;
    end else if (m_state == 1) begin
      if (ack) begin
        m_left--; m_req = 0;
        if (!m_dir && m_padl > 0) m_padl--;
      end else if (!m_req) begin
        if (m_dir && m_padl > 0) begin
          if (m_en && !tx_empty) m_padl--;
        end else if (m_left > 0) begin
          if (m_en) m_req = 1;
        end else if (m_dir) begin
          m_state = 0; m_done = 1;
        end else begin
          m_state = 2;
        end
      end
    end else if (m_state == 2 && rx_empty) begin
      m_state = 0; m_done = 1;
    end
    if (ctrl) begin
      m_en = wr_data[0];
      if (!busy) m_dir = wr_data[2];
      m_ie_rx = wr_data[5]; m_ie_tx = wr_data[6]; m_ie_d = wr_data[7];
      if (wr_data[8]) m_err = 0;
    end
    if (wr_en && (wr_sel == 2'd1 || wr_sel == 2'd2)) begin
      if (busy) m_err = 1;
      else if (wr_sel == 2'd1) m_cnt = int'(wr_data[15:0]);
      else begin m_addr = int'(wr_data[5:0]); m_dev = int'(wr_data[9:8]); end
    end
  endtask

  // one cycle: inputs already set after a negedge
  task automatic tick();
    acc_ack = m_req && (eng_wait >= lat);
    #1;
    compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; acc_ack = 1'b0;
    rx_empty = 1'b1; rx_need = 1'b0; tx_empty = 1'b0; tx_need = 1'b0;
    lat = 1; eng_wait = 0; m_rpipe = 2'b00; model_reset();
    @(negedge clk);
    run(3);                       // R1 reset state
    rst_n = 1'b1;
    run(4);

    // R2 R3: read of 4 beats, done held while FIFO not empty
    reg_wr(2'd2, 32'h0000_022A);
    reg_wr(2'd1, 32'd4);
    rx_empty = 1'b0;
    reg_wr(2'd0, 32'h0000_0083);
    run(3);
    reg_wr(2'd0, 32'h0000_0087);  // R1 start while active ignored
    reg_wr(2'd1, 32'd9);          // R7 setup write while active
    run(20);
    rx_empty = 1'b1;              // R3 drain completes
    run(4);
    reg_wr(2'd0, 32'h0000_0101);  // R7 clear error
    run(2);

    // R4: read of 5 beats with 2 pad beats, zero latency
    lat = 0;
    reg_wr(2'd1, 32'd5);
    reg_wr(2'd0, 32'h0000_0013);
    run(20);

    // R5: write with 3 pad entries, TX FIFO empty at first
    lat = 3;
    tx_empty = 1'b1;
    reg_wr(2'd1, 32'd3);
    reg_wr(2'd2, 32'h0000_0115);
    reg_wr(2'd0, 32'h0000_001F);
    run(5);
    tx_empty = 1'b0;
    run(25);

    // R6: enable dropped mid-transfer, then restored
    lat = 2;
    reg_wr(2'd0, 32'h0000_0007);
    run(3);
    reg_wr(2'd0, 32'h0000_0000);
    run(10);
    reg_wr(2'd0, 32'h0000_0002);  // R1 start without enable ignored
    run(3);
    reg_wr(2'd0, 32'h0000_0001);
    run(20);
    reg_wr(2'd0, 32'h0000_0002);  // R1 idle start with enable 0
    run(4);

    // R9: zero-length write
    reg_wr(2'd1, 32'd0);
    reg_wr(2'd0, 32'h0000_0087);
    run(4);

    // R8: interrupt sources
    reg_wr(2'd0, 32'h0000_0061);
    rx_need = 1'b1; run(2);
    rx_need = 1'b0; tx_need = 1'b1; run(2);
    tx_need = 1'b0; run(2);
    reg_wr(2'd0, 32'h0000_0081);
    run(2);
    rx_need = 1'b1; tx_need = 1'b1;
    reg_wr(2'd0, 32'h0000_0001);
    run(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule